// File: doc/BRIEF.md
# Interleaved Dual-Bank Burst Read Sequencer

This block steers burst reads from a word array that is split in two halves by the lowest address bit: words at even addresses sit in one bank and words at odd addresses in the other. When chip enable is low, a strobe on the address-latch input loads a random start address. Every later output-enable cycle presents one word. It takes that word from whichever bank holds the current priority, then advances that bank's own counter, then hands priority to the other bank. The result is a linear stream of words at consecutive addresses that runs past the top of the array and continues from address zero, with no length limit.

Chip enable going high parks the sequence in standby. Both counters and the bank pointer hold, so a later cycle with chip enable low and no load strobe continues the stream where it stopped. Each bank array is modelled by a fixed mixing function of the word address, which gives every word a distinct, checkable value. After a load, the output stays in high impedance until the first word of the new stream has been presented.

Top module: `ilv_burst_seq`

## Requirements
- R1: Out of reset, both bank indices are 0, the bank select is 0 (even), data valid is 0, the high-impedance control is 1 and the standby flag is 1.
- R2: A cycle with address latch 1 and chip enable low (0) loads start address A. The cycle after it shows bank select = A[0], odd index = A[15:1], even index = A[15:1] + A[0] (modulo 2^15), data valid 0 and high impedance 1. A load wins over a step in the same cycle.
- R3: A step cycle has chip enable 0, address latch 0 and output enable low (0), and follows an earlier load. The cycle after it shows data valid 1, high impedance 0, a word address equal to {index of the selected bank, bank select}, and data equal to the low 16 bits of ((word address × 0x9E3779B1) XOR 0xA5A55A5A) in 32-bit arithmetic.
- R4: Each step increments only the selected bank's index by 1 and flips the bank select. The other bank's index holds, so consecutive words come from consecutive addresses that alternate even and odd.
- R5: Indices wrap modulo 2^15, so the word stream runs 0xFFFE, 0xFFFF, 0x0000, 0x0001 without stopping.
- R6: A cycle with chip enable 1 holds both indices and the bank select. The cycle after it shows data valid 0, high impedance 1 and standby 1. Address latch is ignored in such a cycle.
- R7: After a standby period, step cycles continue from the held indices without reloading.
- R8: A cycle with chip enable 0, address latch 0 and output enable 1 holds the indices and bank select, gives data valid 0, and leaves the high-impedance control unchanged.
- R9: Before the first load after reset, step cycles present no word and move no index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sequential cycle per edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Start word address, sampled on a load |
| ale_i | input | 1 | Address latch strobe, active high |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low; requests the next word |
| bank_sel_o | output | 1 | Bank holding priority: 0 even, 1 odd |
| even_idx_o | output | 15 | Current even-bank word index |
| odd_idx_o | output | 15 | Current odd-bank word index |
| word_addr_o | output | 16 | Address of the word last presented |
| data_o | output | 16 | Word last presented |
| data_valid_o | output | 1 | A word was presented in the previous cycle |
| out_hiz_o | output | 1 | Data output should be high impedance |
| standby_o | output | 1 | Chip enable was high in the previous cycle |

## Verification
The bench tracks one linear pointer and derives both bank indices from it. A design that stepped both counters together, or that failed to pre-advance the even counter after an odd start, breaks the alternating address stream at the first even word. Directed runs start at 0xFFFD so that the pass through 0x0000 is covered. They also suspend in mid-burst, and they strobe the address latch with chip enable high. A design that lost its counters in standby, or that took a load while deselected, would restart at the wrong address. Random mixes of loads, idles and output-enable gaps catch a high-impedance control that reopens before the first word after a load.

// File: rtl/ilv_pkg.sv
`timescale 1ns/1ps
package ilv_pkg;

  localparam int unsigned ILV_ADDR_W = 16;
  localparam int unsigned ILV_DATA_W = 16;

  // One event per cycle, decoded by the controller
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_LOAD = 2'd1,
    EV_STEP = 2'd2,
    EV_STBY = 2'd3
  } ilv_event_e;

  // Stored word model: fixed mix of the linear word address
  function automatic logic [31:0] ilv_word_mix(input logic [31:0] lin);
    return (lin * 32'h9E37_79B1) ^ 32'hA5A5_5A5A;
  endfunction

  // Counter value a bank takes on a load; even bank skips ahead after an odd start
  function automatic logic [31:0] ilv_load_index(input logic [31:0] addr,
                                                 input logic even_bank);
    return (addr >> 1) + ((even_bank && addr[0]) ? 32'd1 : 32'd0);
  endfunction

  // Linear word address formed from a bank index and the bank select
  function automatic logic [31:0] ilv_join(input logic [31:0] idx, input logic bank);
    return {idx[30:0], bank};
  endfunction

endpackage

// File: rtl/ilv_ctrl.sv
`timescale 1ns/1ps
module ilv_ctrl
  import ilv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ale_i,
  input  logic       ce_n_i,
  input  logic       oe_n_i,
  input  logic       addr0_i,
  output ilv_event_e ev_o,
  output logic       sel_o,
  output logic       armed_o
);

  logic armed_q;
  logic sel_q;

  // Priority: load, then standby, then step
  always_comb begin
    if (!ce_n_i && ale_i)             ev_o = EV_LOAD;
    else if (ce_n_i)                  ev_o = EV_STBY;
    else if (!oe_n_i && armed_q)      ev_o = EV_STEP;
    else                              ev_o = EV_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      case (ev_o)
        EV_LOAD: begin
          armed_q <= 1'b1;
          sel_q   <= addr0_i;
        end
        EV_STEP: sel_q <= ~sel_q;
        default: ;
      endcase
    end
  end

  assign sel_o   = sel_q;
  assign armed_o = armed_q;

endmodule

// File: rtl/ilv_bank_ctr.sv
`timescale 1ns/1ps
module ilv_bank_ctr #(
  parameter int unsigned IDX_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [IDX_W-1:0] load_idx_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o
);

  logic [IDX_W-1:0] idx_q;

  // Wraps modulo 2^IDX_W by width truncation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (load_i)  idx_q <= load_idx_i;
    else if (adv_i)   idx_q <= idx_q + IDX_W'(1);
  end

  assign idx_o = idx_q;

endmodule

// File: rtl/ilv_out_stage.sv
`timescale 1ns/1ps
module ilv_out_stage
  import ilv_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ilv_event_e        ev_i,
  input  logic [ADDR_W-1:0] lin_i,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              hiz_o,
  output logic              stby_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              valid_q, hiz_q, stby_q;
  logic [DATA_W-1:0] mixed;

  assign mixed = DATA_W'(ilv_word_mix(32'(lin_i)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      hiz_q   <= 1'b1;
      stby_q  <= 1'b1;
    end else begin
      valid_q <= (ev_i == EV_STEP);
      stby_q  <= (ev_i == EV_STBY);
      case (ev_i)
        EV_LOAD, EV_STBY: hiz_q <= 1'b1;
        EV_STEP: begin
          hiz_q  <= 1'b0;
          addr_q <= lin_i;
          data_q <= mixed;
        end
        default: ;
      endcase
    end
  end

  assign word_addr_o = addr_q;
  assign data_o      = data_q;
  assign valid_o     = valid_q;
  assign hiz_o       = hiz_q;
  assign stby_o      = stby_q;

endmodule

// File: rtl/ilv_burst_seq.sv
`timescale 1ns/1ps
module ilv_burst_seq
  import ilv_pkg::*;
#(
  parameter int unsigned ADDR_W = ILV_ADDR_W,
  parameter int unsigned DATA_W = ILV_DATA_W,
  localparam int unsigned IDX_W = ADDR_W - 1,
  localparam int unsigned NBANK = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ale_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  output logic              bank_sel_o,
  output logic [IDX_W-1:0]  even_idx_o,
  output logic [IDX_W-1:0]  odd_idx_o,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_valid_o,
  output logic              out_hiz_o,
  output logic              standby_o
);

  ilv_event_e        ev_w;
  logic              sel_w;
  logic              armed_w;
  logic              load_w;
  logic              step_w;
  logic [IDX_W-1:0]  idx_w [NBANK];
  logic [IDX_W-1:0]  cur_idx_w;
  logic [ADDR_W-1:0] lin_w;

  ilv_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ale_i   (ale_i),
    .ce_n_i  (ce_n_i),
    .oe_n_i  (oe_n_i),
    .addr0_i (addr_i[0]),
    .ev_o    (ev_w),
    .sel_o   (sel_w),
    .armed_o (armed_w)
  );

  assign load_w = (ev_w == EV_LOAD);
  assign step_w = (ev_w == EV_STEP);

  // Bank 0 holds even words, bank 1 odd words
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [IDX_W-1:0] ld_idx;
    logic             adv;
    assign ld_idx = IDX_W'(ilv_load_index(32'(addr_i), (b == 0)));
    assign adv    = step_w && (sel_w == b[0]);
    ilv_bank_ctr #(.IDX_W(IDX_W)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_w),
      .load_idx_i (ld_idx),
      .adv_i      (adv),
      .idx_o      (idx_w[b])
    );
  end

  assign cur_idx_w = sel_w ? idx_w[1] : idx_w[0];
  assign lin_w     = ADDR_W'(ilv_join(32'(cur_idx_w), sel_w));

  ilv_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_i        (ev_w),
    .lin_i       (lin_w),
    .word_addr_o (word_addr_o),
    .data_o      (data_o),
    .valid_o     (data_valid_o),
    .hiz_o       (out_hiz_o),
    .stby_o      (standby_o)
  );

  assign bank_sel_o = sel_w;
  assign even_idx_o = idx_w[0];
  assign odd_idx_o  = idx_w[1];

endmodule

// File: rtl/ilv_burst_seq_chk.sv
`timescale 1ns/1ps
module ilv_burst_seq_chk
  import ilv_pkg::*;
#(
  parameter int unsigned IDX_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input ilv_event_e       ev,
  input logic             armed,
  input logic             bank,
  input logic [IDX_W-1:0] even_idx,
  input logic [IDX_W-1:0] odd_idx,
  input logic             valid,
  input logic             hiz,
  input logic             stby
);

  assert_load_closes_output_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_LOAD |=> hiz && !valid);

  assert_word_opens_output_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !hiz);

  assert_step_flips_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_STEP |=> bank != $past(bank));

  assert_even_step_moves_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_STEP && !bank) |=> even_idx == $past(even_idx) + IDX_W'(1) && $stable(odd_idx));

  assert_odd_step_moves_odd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_STEP && bank) |=> odd_idx == $past(odd_idx) + IDX_W'(1) && $stable(even_idx));

  assert_standby_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_STBY |=> $stable(even_idx) && $stable(odd_idx) && $stable(bank) && !valid && hiz && stby);

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_NONE |=> $stable(even_idx) && $stable(odd_idx) && !valid && $stable(hiz));

  assert_no_step_unarmed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> ev != EV_STEP);

endmodule

bind ilv_burst_seq ilv_burst_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ev       (ev_w),
  .armed    (armed_w),
  .bank     (bank_sel_o),
  .even_idx (even_idx_o),
  .odd_idx  (odd_idx_o),
  .valid    (data_valid_o),
  .hiz      (out_hiz_o),
  .stby     (standby_o)
);

// File: tb/tb_ilv_burst_seq.sv
`timescale 1ns/1ps
module tb_ilv_burst_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        ale = 1'b0, ce_n = 1'b1, oe_n = 1'b1;
  logic        bank_sel, valid, hiz, stby;
  logic [14:0] even_idx, odd_idx;
  logic [15:0] word_addr, data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // Reference state: one linear pointer stands for both counters
  logic [15:0] m_ptr = '0;
  logic        m_armed = 1'b0;
  logic        m_hiz = 1'b1;
  logic        m_valid = 1'b0;
  logic        m_stby = 1'b1;
  logic [15:0] m_lin = '0;

  always #5 clk = ~clk;

  ilv_burst_seq dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .ale_i(ale), .ce_n_i(ce_n), .oe_n_i(oe_n),
    .bank_sel_o(bank_sel), .even_idx_o(even_idx), .odd_idx_o(odd_idx),
    .word_addr_o(word_addr), .data_o(data), .data_valid_o(valid),
    .out_hiz_o(hiz), .standby_o(stby)
  );

  function automatic logic [15:0] exp_word(input logic [15:0] lin);
    logic [31:0] prod;
    prod = 32'(lin) * 32'd2654435761;
    return 16'(prod ^ 32'd2779077210);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "bank",  32'(bank_sel), 32'(m_ptr[0]));
    chk(req, "odd",   32'(odd_idx),  32'(m_ptr[15:1]));
    chk(req, "even",  32'(even_idx), 32'(15'(m_ptr[15:1] + 15'(m_ptr[0]))));
    chk(req, "valid", 32'(valid),    32'(m_valid));
    chk(req, "hiz",   32'(hiz),      32'(m_hiz));
    chk(req, "stby",  32'(stby),     32'(m_stby));
    if (m_valid) begin
      chk(req, "addr", 32'(word_addr), 32'(m_lin));
      chk(req, "data", 32'(data),      32'(exp_word(m_lin)));
    end
  endtask

  task automatic cycle(input logic a_le, input logic c_n, input logic o_n,
                       input logic [15:0] ad, input string req);
    @(negedge clk);
    ale = a_le; ce_n = c_n; oe_n = o_n; addr = ad;
    m_stby = 1'b0;
    if (!c_n && a_le) begin
      m_ptr = ad; m_armed = 1'b1; m_hiz = 1'b1; m_valid = 1'b0;
    end else if (c_n) begin
      m_hiz = 1'b1; m_valid = 1'b0; m_stby = 1'b1;
    end else if (!o_n && m_armed) begin
      m_lin = m_ptr; m_valid = 1'b1; m_hiz = 1'b0; m_ptr = m_ptr + 16'd1;
    end else begin
      m_valid = 1'b0;
    end
    @(posedge clk); #1;
    check_all(req);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    #1;
    check_all("R1");                             // R1 reset state
    rst_n = 1'b1;

    // R9: steps before any load do nothing
    for (int i = 0; i < 3; i++) cycle(0, 0, 0, 16'h1234, "R9");

    // R2/R3/R4: even start
    cycle(1, 0, 0, 16'h0010, "R2");
    for (int i = 0; i < 5; i++) cycle(0, 0, 0, '0, "R3");
    // Odd start: even counter pre-advanced
    cycle(1, 0, 1, 16'h0021, "R2");
    for (int i = 0; i < 4; i++) cycle(0, 0, 0, '0, "R4");

    // R5: wrap through the top of the array
    cycle(1, 0, 0, 16'hFFFD, "R5");
    for (int i = 0; i < 5; i++) cycle(0, 0, 0, '0, "R5");

    // R6/R7: suspend mid-burst, latch strobe ignored, resume
    cycle(1, 0, 0, 16'h4002, "R2");
    cycle(0, 0, 0, '0, "R3");
    cycle(0, 1, 0, '0, "R6");
    cycle(1, 1, 0, 16'h7777, "R6");
    cycle(0, 1, 1, 16'h0001, "R6");
    for (int i = 0; i < 3; i++) cycle(0, 0, 0, '0, "R7");

    // R8: output enable high holds everything
    cycle(0, 0, 1, '0, "R8");
    cycle(0, 0, 1, 16'hAAAA, "R8");
    cycle(0, 0, 0, '0, "R7");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [15:0] ad;
      r  = $urandom() % 16;
      ad = 16'($urandom());
      if (r == 15) ad = 16'hFFFC | 16'($urandom() % 4);
      if (r < 2)       cycle(1, 0, 1'($urandom()), ad, "R2");
      else if (r == 2) cycle(1'($urandom()), 1, 1'($urandom()), ad, "R6");
      else if (r == 3) cycle(0, 0, 1, ad, "R8");
      else if (r == 15) cycle(1, 0, 0, ad, "R5");
      else             cycle(0, 0, 0, ad, "R4");
    end

    finish_run();
  end

endmodule